// File: doc/BRIEF.md
# AHB-Lite Burst Request Splitter

This block sits between a processor core's memory request port and an AHB-Lite master port. The core hands over one request at a time. Each request carries a start address, a length in 32-bit words, a direction, an access size, an instruction-fetch flag and a cache-linefill flag. The block turns the request into bus transfers and uses only four kinds of transfer: single beats, four-beat incrementing bursts, eight-beat incrementing bursts and eight-beat wrapping bursts. A request whose length is not one of the legal burst lengths is cut into consecutive legal packets. Together these packets cover every word of the request.

The block aligns each address to the size of its access, drives the control signals on the bus and steps the beat address. It hands write data from the core to the bus one beat at a time and returns read data as each data phase finishes. Completion is signalled only after the data phase of the last beat is done. An ERROR response from a slave ends the request early and is reported with the completion.

Top module: `ahbl_burst_splitter`

## Requirements
- R1: On every active transfer, HBURST is one of four codes: SINGLE 3'b000, INCR4 3'b011, WRAP8 3'b100 or INCR8 3'b101.
- R2: A non-linefill request of N words (1 to 63) is split greedily. INCR8 packets are issued while at least 8 words remain, then INCR4 packets while at least 4 remain, then SINGLE packets for the rest. Exactly N beats are issued.
- R3: HTRANS is NONSEQ (2'b10) on the first beat of each packet and SEQ (2'b11) on the other beats of that packet. It is IDLE (2'b00) when no beat is presented.
- R4: In a non-linefill request, each beat's address is 4 greater than the previous beat's address. This holds inside a packet and from one packet to the next.
- R5: A linefill request (req_linefill=1) is a single WRAP8 read of 8 beats. The first beat is the requested word. Later beats step by 4 inside the 32-byte-aligned line and wrap from its top back to its base. req_len and req_write are ignored for a linefill.
- R6: A one-word request that is neither a fetch nor a linefill takes its HSIZE from req_size: 0 gives byte (3'b000), 1 gives halfword (3'b001), and 2 or 3 give word (3'b010). A halfword access clears address bit 0. A word access clears address bits 1:0. Multi-word requests always use word size.
- R7: An instruction fetch (req_fetch=1) always uses word size and a word-aligned address, whatever req_size says.
- R8: While HREADY is low with an OKAY response, HADDR, HTRANS and HBURST stay unchanged and no new beat is started.
- R9: req_ready is high only when the block is idle. A request is taken when req_valid and req_ready are both high. cmp_valid pulses for one cycle after the data phase of the last beat completes.
- R10: wr_take is high in the cycle where the address phase of a write beat is accepted. The wr_data value present in that cycle appears on HWDATA during that beat's data phase.
- R11: When a read data phase completes with OKAY, rd_valid is high and rd_data equals HRDATA.
- R12: In the first cycle of an ERROR response (HRESP=1, HREADY=0), the pending address phase is cancelled to IDLE. No further beats of the request are issued, and the completion carries cmp_err=1.
- R13: A synchronous active-high reset puts the block in idle: HTRANS IDLE, req_ready high, cmp_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in words (1 or more) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word (used for one-word requests only) |
| req_linefill | input | 1 | Cache line fill: WRAP8 read |
| req_fetch | input | 1 | Instruction fetch: forces word size |
| wr_data | input | DATA_W | Next write word from the core |
| wr_take | output | 1 | wr_data consumed this cycle |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | rd_data is valid this cycle |
| cmp_valid | output | 1 | Request finished (one-cycle pulse) |
| cmp_err | output | 1 | The finished request saw an ERROR response |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Bus transfer type |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus transfer size |
| hburst | output | 3 | Bus burst type |
| hwdata | output | DATA_W | Bus write data |
| hrdata | input | DATA_W | Bus read data |
| hready | input | 1 | Transfer done / bus ready |
| hresp | input | 1 | 1 = ERROR response |

## Verification
An error in the remaining-word count becomes visible at the next NONSEQ beat: HBURST is wrong there, or the completion comes one beat early or late. An error in the in-packet position counter becomes visible on the very next accepted beat, either as SEQ following a SINGLE or as NONSEQ in the middle of a burst. If the data-phase tracking is wrong, cmp_valid arrives a cycle early or late, rd_valid appears during a write, or HWDATA is off by one word in the first data phase affected. A wrong cancel on ERROR shows up as an extra accepted beat in the cycle after the error.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [2:0] {
    BU_SINGLE = 3'b000,
    BU_INCR4  = 3'b011,
    BU_WRAP8  = 3'b100,
    BU_INCR8  = 3'b101
  } burst_e;

  localparam logic [2:0] SZ_BYTE = 3'b000;
  localparam logic [2:0] SZ_HALF = 3'b001;
  localparam logic [2:0] SZ_WORD = 3'b010;

endpackage

// File: rtl/split_plan.sv
// Chooses the next packet from the number of words still to be issued.
module split_plan
  import splitter_pkg::*;
#(
  parameter int LEN_W      = 6,
  parameter int LINE_WORDS = 8
) (
  input  logic [LEN_W-1:0] words_left,
  input  logic             line_fill,
  output logic [2:0]       burst,
  output logic [2:0]       beats_m1
);
  localparam logic [LEN_W-1:0] LONG_N  = LEN_W'(LINE_WORDS);
  localparam logic [LEN_W-1:0] SHORT_N = LEN_W'(LINE_WORDS / 2);

  always_comb begin
    if (line_fill) begin
      burst    = BU_WRAP8;
      beats_m1 = 3'(LINE_WORDS - 1);
    end else if (words_left >= LONG_N) begin
      burst    = BU_INCR8;
      beats_m1 = 3'(LINE_WORDS - 1);
    end else if (words_left >= SHORT_N) begin
      burst    = BU_INCR4;
      beats_m1 = 3'(LINE_WORDS / 2 - 1);
    end else begin
      burst    = BU_SINGLE;
      beats_m1 = 3'd0;
    end
  end
endmodule

// File: rtl/beat_addr.sv
// Aligns a start address to its access size and steps a beat address,
// either linearly or wrapping inside one cache line.
module beat_addr #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic [ADDR_W-1:0] raw,
  input  logic [2:0]        size,
  input  logic [ADDR_W-1:0] cur,
  input  logic              wrap,
  output logic [ADDR_W-1:0] aligned,
  output logic [ADDR_W-1:0] next
);
  localparam int LINE_BITS = $clog2(LINE_WORDS) + 2;
  localparam int IDX_W     = LINE_BITS - 2;

  logic [IDX_W-1:0] word_idx;

  always_comb begin
    case (size)
      3'b000:  aligned = raw;
      3'b001:  aligned = {raw[ADDR_W-1:1], 1'b0};
      default: aligned = {raw[ADDR_W-1:2], 2'b00};
    endcase
  end

  always_comb begin
    word_idx = cur[LINE_BITS-1:2] + {{(IDX_W-1){1'b0}}, 1'b1};
    if (wrap) next = {cur[ADDR_W-1:LINE_BITS], word_idx, 2'b00};
    else      next = cur + ADDR_W'(4);
  end
endmodule

// File: rtl/ahbl_burst_splitter.sv
module ahbl_burst_splitter
  import splitter_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_linefill,
  input  logic              req_fetch,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_take,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              cmp_valid,
  output logic              cmp_err,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DATA_W-1:0] hwdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hready,
  input  logic              hresp
);
  localparam int LINE_WORDS = 8;
  localparam int LINE_BITS  = $clog2(LINE_WORDS) + 2;
  localparam logic [LEN_W-1:0] ONE_W = LEN_W'(1);

  // control state
  logic             busy;
  logic             fill_q;
  logic [LEN_W-1:0] rem_q;     // words still to issue after the presented beat
  logic [2:0]       pos_q;     // beats left in the packet after the presented beat
  logic             dp_valid;
  logic             dp_write;
  logic             dp_last;

  // start-of-request decode
  logic [LEN_W-1:0]  len_eff;
  logic [2:0]        start_sz;
  logic [2:0]        first_burst, first_m1;
  logic [2:0]        cont_burst, cont_m1;
  logic [ADDR_W-1:0] start_addr, step_addr;

  logic a_acc, err_first, dp_done;

  always_comb begin
    len_eff = req_linefill ? LEN_W'(LINE_WORDS) : req_len;
    if (req_fetch || req_linefill || req_len != ONE_W || req_size == 2'd3)
      start_sz = SZ_WORD;
    else
      start_sz = {1'b0, req_size};
  end

  split_plan #(.LEN_W(LEN_W), .LINE_WORDS(LINE_WORDS)) u_plan_first (
    .words_left(len_eff), .line_fill(req_linefill),
    .burst(first_burst), .beats_m1(first_m1)
  );

  split_plan #(.LEN_W(LEN_W), .LINE_WORDS(LINE_WORDS)) u_plan_next (
    .words_left(rem_q), .line_fill(1'b0),
    .burst(cont_burst), .beats_m1(cont_m1)
  );

  beat_addr #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_addr (
    .raw(req_addr), .size(start_sz), .cur(haddr), .wrap(fill_q),
    .aligned(start_addr), .next(step_addr)
  );

  assign a_acc     = (htrans != TR_IDLE) && hready;
  assign err_first = dp_valid && !hready && hresp;
  assign dp_done   = dp_valid && hready;

  assign req_ready = !busy;
  assign wr_take   = a_acc && hwrite;
  assign rd_valid  = dp_done && !dp_write && !hresp;
  assign rd_data   = hrdata;

  // data phase tracking and completion
  always_ff @(posedge clk) begin
    if (rst) begin
      dp_valid  <= 1'b0;
      dp_write  <= 1'b0;
      dp_last   <= 1'b0;
      hwdata    <= '0;
      cmp_valid <= 1'b0;
      cmp_err   <= 1'b0;
    end else begin
      cmp_valid <= 1'b0;
      cmp_err   <= 1'b0;
      if (hready) begin
        dp_valid <= a_acc;
        dp_write <= hwrite;
        dp_last  <= (rem_q == '0);
        if (a_acc && hwrite) hwdata <= wr_data;
      end
      if (dp_done && (dp_last || hresp)) begin
        cmp_valid <= 1'b1;
        cmp_err   <= hresp;
      end
    end
  end

  // address phase sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      fill_q <= 1'b0;
      rem_q  <= '0;
      pos_q  <= '0;
      haddr  <= '0;
      htrans <= TR_IDLE;
      hwrite <= 1'b0;
      hsize  <= SZ_WORD;
      hburst <= BU_SINGLE;
    end else begin
      if (dp_done && (dp_last || hresp)) busy <= 1'b0;
      if (err_first) begin
        htrans <= TR_IDLE;
        rem_q  <= '0;
        pos_q  <= '0;
      end else if (a_acc) begin
        if (rem_q == '0) begin
          htrans <= TR_IDLE;
        end else if (pos_q != 3'd0) begin
          htrans <= TR_SEQ;
          haddr  <= step_addr;
          pos_q  <= pos_q - 3'd1;
          rem_q  <= rem_q - ONE_W;
        end else begin
          htrans <= TR_NONSEQ;
          haddr  <= step_addr;
          hburst <= cont_burst;
          pos_q  <= cont_m1;
          rem_q  <= rem_q - ONE_W;
        end
      end else if (!busy && req_valid) begin
        busy   <= 1'b1;
        fill_q <= req_linefill;
        htrans <= TR_NONSEQ;
        haddr  <= start_addr;
        hburst <= first_burst;
        hsize  <= start_sz;
        hwrite <= req_write && !req_linefill;
        pos_q  <= first_m1;
        rem_q  <= len_eff - ONE_W;
      end
    end
  end

  // R1: only the four legal burst codes reach the bus
  a_r1_legal_burst: assert property (@(posedge clk) disable iff (rst)
    (htrans != TR_IDLE) |-> (hburst == BU_SINGLE || hburst == BU_INCR4 ||
                             hburst == BU_INCR8  || hburst == BU_WRAP8));

  // R3: a SEQ beat never belongs to a single transfer
  a_r3_seq_in_burst: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_SEQ) |-> (hburst != BU_SINGLE));

  // R5: wrapping beats stay inside one line
  a_r5_wrap_in_line: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_SEQ && hburst == BU_WRAP8) |->
      (haddr[ADDR_W-1:LINE_BITS] == $past(haddr[ADDR_W-1:LINE_BITS])));

  // R6: alignment follows the driven size
  a_r6_word_align: assert property (@(posedge clk) disable iff (rst)
    (htrans != TR_IDLE && hsize == SZ_WORD) |-> (haddr[1:0] == 2'b00));
  a_r6_half_align: assert property (@(posedge clk) disable iff (rst)
    (htrans != TR_IDLE && hsize == SZ_HALF) |-> (haddr[0] == 1'b0));

  // R8: address and control held through wait states
  a_r8_hold_ctrl: assert property (@(posedge clk) disable iff (rst)
    (htrans != TR_IDLE && !hready && !hresp) |=>
      ($stable(haddr) && $stable(htrans) && $stable(hburst)));

  // R9: completion only once the address phase has gone idle
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |-> (htrans == TR_IDLE));

  // R12: the first error cycle cancels the pending address phase
  a_r12_cancel_on_error: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && !hready && hresp) |=> (htrans == TR_IDLE));

endmodule

// File: tb/ahbl_burst_splitter_test.sv
`timescale 1ns/1ps
module ahbl_burst_splitter_test;

  typedef struct packed {
    logic [31:0] addr;
    logic [5:0]  len;
    logic        wr;
    logic [1:0]  size;
    logic        lf;
    logic        fetch;
    logic        waits;
    logic [5:0]  errb;   // 63 = no error
    logic [5:0]  pkts;   // expected NONSEQ count
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'h0000_0100,  6'd1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 6'd63, 6'd1},
    '{32'h0000_0203,  6'd1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 6'd63, 6'd1},
    '{32'h0000_0203,  6'd1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 6'd63, 6'd1},
    '{32'h0000_0207,  6'd1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 6'd63, 6'd1},
    '{32'h0000_1000,  6'd4, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 6'd63, 6'd1},
    '{32'h0000_2000,  6'd8, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 6'd63, 6'd1},
    '{32'h0000_3000, 6'd13, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 6'd63, 6'd3},
    '{32'h0000_4000,  6'd7, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 6'd63, 6'd4},
    '{32'h0000_5014,  6'd3, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 6'd63, 6'd1},
    '{32'h0000_5001,  6'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 6'd63, 6'd1},
    '{32'h0000_6002, 6'd20, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 6'd63, 6'd3},
    '{32'h0000_7000, 6'd12, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0,  6'd5, 6'd1},
    '{32'h0000_8000,  6'd3, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0,  6'd0, 6'd1},
    '{32'h0000_901C,  6'd8, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 6'd63, 6'd1},
    '{32'h0000_A000, 6'd63, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 6'd63, 6'd11},
    '{32'h0000_B204,  6'd5, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 6'd63, 6'd2},
    '{32'h0000_C002,  6'd1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 6'd63, 6'd1},
    '{32'h0000_D004, 6'd12, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0,  6'd9, 6'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [5:0]  req_len = 6'd1;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic        req_linefill = 1'b0;
  logic        req_fetch = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_take;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        cmp_valid, cmp_err;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize, hburst;
  logic [31:0] hwdata;
  logic [31:0] hrdata = '0;
  logic        hready = 1'b1;
  logic        hresp = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  // expected beat list and slave bookkeeping
  logic [31:0] e_addr  [0:63];
  logic [1:0]  e_trans [0:63];
  logic [2:0]  e_burst [0:63];
  int          e_n = 0;
  logic [2:0]  e_size = 3'd2;
  logic        e_wr = 1'b0;
  int          acc = 0, nseq = 0, rdc = 0, wr_idx = 0;
  int          err_at = 63, err_st = 0;
  logic        waits = 1'b0;
  logic [31:0] wpat = 32'hC0DE_0000;

  always #4 clk = ~clk;

  ahbl_burst_splitter uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .req_size(req_size),
    .req_linefill(req_linefill), .req_fetch(req_fetch),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .cmp_valid(cmp_valid), .cmp_err(cmp_err),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata),
    .hready(hready), .hresp(hresp)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench model of the splitting, wrapping and alignment rules
  task automatic build(input vec_t v);
    logic [31:0] a;
    int rem, b, k;
    k = 0;
    e_size = (v.lf || v.fetch || v.len != 6'd1 || v.size == 2'd3) ? 3'd2 : {1'b0, v.size};
    e_wr   = v.wr && !v.lf;
    if (e_size == 3'd2)      a = {v.addr[31:2], 2'b00};
    else if (e_size == 3'd1) a = {v.addr[31:1], 1'b0};
    else                     a = v.addr;
    if (v.lf) begin
      for (int i = 0; i < 8; i++) begin
        e_addr[i]  = {a[31:5], 3'(a[4:2] + 3'(i)), 2'b00};
        e_trans[i] = (i == 0) ? 2'b10 : 2'b11;
        e_burst[i] = 3'b100;
      end
      e_n = 8;
    end else begin
      rem = int'(v.len);
      while (rem > 0) begin
        b = (rem >= 8) ? 8 : ((rem >= 4) ? 4 : 1);
        for (int j = 0; j < b; j++) begin
          e_addr[k]  = a;
          e_trans[k] = (j == 0) ? 2'b10 : 2'b11;
          e_burst[k] = (b == 8) ? 3'b101 : ((b == 4) ? 3'b011 : 3'b000);
          a = a + 32'd4;
          k++;
        end
        rem -= b;
      end
      e_n = k;
    end
  endtask

  // slave model: responds, checks each accepted beat and each data phase
  initial begin : slave
    logic        s_dp, s_wr, w_done, hold_chk, took;
    logic [31:0] s_addr, h_addr;
    logic [1:0]  h_tr;
    int          s_idx;
    s_dp = 0; s_wr = 0; w_done = 0; hold_chk = 0; took = 0;
    s_addr = '0; h_addr = '0; h_tr = '0; s_idx = 0;
    forever begin
      @(negedge clk);
      if (rst) begin s_dp = 0; hold_chk = 0; err_st = 0; w_done = 0; end
      if (hold_chk) begin
        chk(haddr == h_addr && htrans == h_tr, "R8 control held in wait state", haddr, h_addr);
        hold_chk = 0;
      end
      if (s_dp && err_st == 0 && s_idx == err_at) begin
        hready = 1'b0; hresp = 1'b1; err_st = 1;
      end else if (err_st == 1) begin
        hready = 1'b1; hresp = 1'b1; err_st = 2;
      end else if (s_dp && waits && !w_done) begin
        hready = 1'b0; hresp = 1'b0; w_done = 1;
      end else begin
        hready = 1'b1; hresp = 1'b0;
      end
      hrdata = s_dp ? pat(s_addr) : 32'h0;
      #1;
      took = 0;
      if (!hready && !hresp && htrans != 2'b00) begin
        hold_chk = 1; h_addr = haddr; h_tr = htrans;
      end
      if (hready) begin
        if (s_dp && !hresp) begin
          if (s_wr) chk(hwdata == wpat + 32'(s_idx), "R10 write data on bus", hwdata, wpat + 32'(s_idx));
          else begin
            chk(rd_valid && rd_data == pat(s_addr), "R11 read data returned", rd_data, pat(s_addr));
            rdc++;
          end
        end
        w_done = 0;
        if (htrans != 2'b00) begin
          if (acc < e_n) begin
            chk(haddr == e_addr[acc], "R4 beat address", haddr, e_addr[acc]);
            chk(htrans == e_trans[acc], "R3 transfer type", 32'(htrans), 32'(e_trans[acc]));
            chk(hburst == e_burst[acc], "R2 burst code", 32'(hburst), 32'(e_burst[acc]));
            chk(hsize == e_size, "R6 transfer size", 32'(hsize), 32'(e_size));
            chk(hwrite == e_wr, "R5 direction", 32'(hwrite), 32'(e_wr));
          end else begin
            chk(1'b0, "R2 extra beat issued", 32'(acc), 32'(e_n));
          end
          if (htrans == 2'b10) nseq++;
          took = wr_take;
          s_dp = 1; s_addr = haddr; s_idx = acc; s_wr = hwrite;
          acc++;
        end else begin
          s_dp = 0;
        end
      end
      @(posedge clk);
      #1;
      if (took) wr_idx++;
      wr_data = wpat + 32'(wr_idx);
    end
  end

  task automatic run_vec(input vec_t v, input int id);
    int exp_acc, exp_rd, cyc;
    bit got;
    build(v);
    acc = 0; nseq = 0; rdc = 0; wr_idx = 0; err_st = 0;
    err_at = int'(v.errb); waits = v.waits;
    wpat = {16'hC0DE, 8'(id), 8'h00};
    @(negedge clk);
    wr_data = wpat;
    req_addr = v.addr; req_len = v.len; req_write = v.wr; req_size = v.size;
    req_linefill = v.lf; req_fetch = v.fetch; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    #2;
    chk(req_ready == 1'b0, "R9 ready low while busy", 32'(req_ready), 32'd0);
    got = 0; cyc = 0;
    while (!got && cyc < 2000) begin
      if (cmp_valid) got = 1;
      else begin @(negedge clk); #2; cyc++; end
    end
    exp_acc = (v.errb == 6'd63) ? e_n : int'(v.errb) + 1;
    exp_rd  = e_wr ? 0 : exp_acc - ((v.errb == 6'd63) ? 0 : 1);
    chk(got, "R9 completion pulse", 32'(got), 32'd1);
    chk(cmp_err == (v.errb != 6'd63), "R12 completion error flag", 32'(cmp_err), 32'(v.errb != 6'd63));
    chk(acc == exp_acc, "R2 beats issued", 32'(acc), 32'(exp_acc));
    chk(nseq == int'(v.pkts), "R2 packet count", 32'(nseq), 32'(v.pkts));
    chk(rdc == exp_rd, "R11 read beats", 32'(rdc), 32'(exp_rd));
    if (e_wr) chk(wr_idx == exp_acc, "R10 write words taken", 32'(wr_idx), 32'(exp_acc));
    @(negedge clk);
    #2;
    chk(cmp_valid == 1'b0, "R9 completion is one cycle", 32'(cmp_valid), 32'd0);
    chk(req_ready == 1'b1, "R9 ready after completion", 32'(req_ready), 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    chk(htrans == 2'b00, "R13 idle transfer in reset", 32'(htrans), 32'd0);
    chk(req_ready == 1'b1, "R13 ready in reset", 32'(req_ready), 32'd1);
    chk(cmp_valid == 1'b0, "R13 no completion in reset", 32'(cmp_valid), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 R8 R10 R11 R12 via the vector table
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R13: reset in the middle of a long write burst
    build(VECS[10]);
    acc = 0; nseq = 0; rdc = 0; wr_idx = 0; err_at = 63; err_st = 0; waits = 1'b0;
    wpat = 32'hC0DE_FF00;
    @(negedge clk);
    wr_data = wpat;
    req_addr = 32'h0000_6000; req_len = 6'd20; req_write = 1'b1; req_size = 2'd2;
    req_linefill = 1'b0; req_fetch = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #2;
    chk(htrans == 2'b00, "R13 idle after mid-burst reset", 32'(htrans), 32'd0);
    chk(req_ready == 1'b1, "R13 ready after mid-burst reset", 32'(req_ready), 32'd1);
    chk(cmp_valid == 1'b0, "R13 no completion after reset", 32'(cmp_valid), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R7: a fetch after reset still comes out word-sized
    run_vec('{32'h0000_E003, 6'd1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 6'd63, 6'd1}, 200);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule